// File: doc/BRIEF.md
# Serial Link Bring-Up Supervisor

This block sequences one port of a serial link from slot reset to a final verdict. It holds the slot in reset for a programmed time, releases it, waits a second programmed delay, then lets the physical layer start training. It watches the newest link-state code and a classifier verdict. When the link reaches the active state it waits for virtual-channel negotiation to finish, then runs an optional device workaround, and records one outcome: success, compliance, failure or no device present.

Three recovery paths loop back to slot reset. A link that came up on fewer lanes than it has asks for a narrower width. A link that is suspected to fail at speed asks to be capped to first-generation speed. A device that asks to be reset during the workaround is retried a bounded number of times. All windows are measured against a free-running microsecond timestamp. A timer restart latches that timestamp, and elapsed time is taken by modulo subtraction, so a counter wrap does no harm.

Top module: `link_bringup_sup`

## Requirements
- R1: On every entry to reset, `slot_rst` and `link_dis` rise together and stay high until the elapsed time reaches `dur_rst_assert`. With a timestamp that advances 1 per cycle and a duration D>=1, they stay high for D+1 cycles, including across a timestamp wrap.
- R2: `hold_train` is 1 out of reset. It falls only after `slot_rst` and `link_dis` have both dropped and `dur_rst_to_train` has elapsed.
- R3: With `cfg_compliance`=1, the port ends in compliance (`st_compliance`) right after training is released, without detection.
- R4: In presence detection, a link code above 4 moves on to detecting. If `dur_rx_detect` runs out first, the outcome is `st_not_present`. After any not-present or fail outcome, `hold_train` is set back to 1 unless `cfg_hotplug`=1.
- R5: In detecting, code 16 means the link is active. If `dur_l0_wait` runs out first, the verdict picks the next step: 0 = fail, 1 = compliance, 2 = broken lane, 3 = speed failure.
- R6: On a broken lane, a `neg_width` that is nonzero and below `phy_lanes` gives a one-cycle `width_req`, with `width_val` = `neg_width`, and reset is re-entered. Any other width goes on to the speed-failure step.
- R7: On a speed failure, if the cap is not yet first-generation (`cfg_gen1_cap`=0 and no earlier request), a one-cycle `gen1_req` is issued and reset is re-entered. Otherwise the port fails.
- R8: While `vc_pending` stays 1, no `retrain` is issued below 1,000,000 us. Once that time has elapsed, one `retrain` pulse is issued and detection restarts.
- R9: Once `vc_pending` is 0, the workaround step runs only if `cfg_wa_en`=1 and `phy_lanes`>=8. Otherwise the port succeeds. Success gives a one-cycle `bw_mgmt_set` as `st_success` rises.
- R10: The workaround status is coded 0 = not ready, 1 = success, 2 = reset device, 3 = treated as not ready. Not ready for 3,000,000 us means fail. Reset device re-enters reset while fewer than 5 retries have been used, and fails after that, so 6 slot resets occur in all.
- R11: At most one outcome flag is ever set. `done` rises after the outcome and stays high until `rst_n`. A fail sets `st_fail` and not `st_not_present`.
- R12: While `rst_n` is low, `slot_rst`, `link_dis`, all strobes, outcome flags and `done` are 0, and `hold_train` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restarts the sequence |
| ts_us | input | TS_W | Free-running microsecond timestamp |
| dur_rst_assert | input | TS_W | Slot reset hold time, us |
| dur_rst_to_train | input | TS_W | Delay from reset release to training release, us |
| dur_rx_detect | input | TS_W | Receiver presence window, us |
| dur_l0_wait | input | TS_W | Wait for the active link state, us |
| link_code | input | CODE_W | Newest link-state code |
| verdict | input | 2 | Classifier verdict (R5 encoding) |
| neg_width | input | LANE_W | Negotiated link width |
| phy_lanes | input | LANE_W | Physical lane count of the port |
| vc_pending | input | 1 | Virtual-channel negotiation still pending |
| cfg_compliance | input | 1 | Compliance mode configured |
| cfg_hotplug | input | 1 | Hotplug enabled |
| cfg_wa_en | input | 1 | Device workaround enabled |
| cfg_gen1_cap | input | 1 | Speed already capped to first generation |
| wa_status | input | 2 | Workaround status (R10 encoding) |
| slot_rst | output | 1 | Slot reset |
| link_dis | output | 1 | Link disable |
| hold_train | output | 1 | Hold training |
| retrain | output | 1 | Retrain strobe |
| width_req | output | 1 | Width reduction request strobe |
| width_val | output | LANE_W | Requested width |
| gen1_req | output | 1 | Force first-generation speed strobe |
| bw_mgmt_set | output | 1 | Bandwidth-management status set strobe |
| st_success | output | 1 | Outcome: success |
| st_compliance | output | 1 | Outcome: compliance |
| st_fail | output | 1 | Outcome: training failure |
| st_not_present | output | 1 | Outcome: no device |
| done | output | 1 | Sequence complete |

## Verification
Random scenarios pick the link-code class (absent, active, stuck), the verdict, the lane counts, the speed cap, hotplug and the workaround settings. Each outcome, the number of width and speed requests, the number of slot resets and the final hold-training level then show which recovery path was taken and how often it looped. Directed cases jump the timestamp to just below and just above the 1,000,000 us and 3,000,000 us limits, which tells a threshold error apart from a wrong path. A reset window that straddles the timestamp wrap, measured cycle by cycle, separates modulo from plain subtraction. The five-retry workaround loop, counted in slot resets, checks the retry bound.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [4:0] {
    ST_RST_ENTER,
    ST_RST_HOLD,
    ST_RST_EXIT,
    ST_TRAIN_WAIT,
    ST_RELEASE,
    ST_PRESENCE,
    ST_DETECT,
    ST_BROKEN,
    ST_SPEED,
    ST_L0,
    ST_VC_WAIT,
    ST_RETRAIN,
    ST_WA,
    ST_FAIL,
    ST_ABSENT,
    ST_SUCCESS,
    ST_COMPLY,
    ST_DONE
  } lbs_state_e;

  localparam logic [1:0] VERDICT_FAIL   = 2'd0;
  localparam logic [1:0] VERDICT_COMPLY = 2'd1;
  localparam logic [1:0] VERDICT_BROKEN = 2'd2;
  localparam logic [1:0] VERDICT_SPEED  = 2'd3;

  localparam logic [1:0] WA_NOT_READY = 2'd0;
  localparam logic [1:0] WA_OK        = 2'd1;
  localparam logic [1:0] WA_RESET_DEV = 2'd2;

endpackage

// File: rtl/lbs_timer.sv
module lbs_timer #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] ts,
  input  logic            restart,
  output logic [TS_W-1:0] elapsed
);

  logic [TS_W-1:0] start_q;

  function automatic logic [TS_W-1:0] wrap_diff(input logic [TS_W-1:0] now,
                                                input logic [TS_W-1:0] then_ts);
    return now - then_ts;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (restart) begin
      start_q <= ts;
    end
  end

  assign elapsed = wrap_diff(ts, start_q);

endmodule

// File: rtl/lbs_retry.sv
module lbs_retry #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  output logic exhausted
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (bump && !exhausted) begin
      used_q <= used_q + 1'b1;
    end
  end

  assign exhausted = (used_q >= CNT_W'(LIMIT));

endmodule

// File: rtl/lbs_outcome.sv
module lbs_outcome (
  input  logic clk,
  input  logic rst_n,
  input  logic set_success,
  input  logic set_comply,
  input  logic set_fail,
  input  logic set_absent,
  input  logic set_done,
  output logic st_success,
  output logic st_compliance,
  output logic st_fail,
  output logic st_not_present,
  output logic done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_success     <= 1'b0;
      st_compliance  <= 1'b0;
      st_fail        <= 1'b0;
      st_not_present <= 1'b0;
      done           <= 1'b0;
    end else begin
      if (set_success) st_success <= 1'b1;
      if (set_comply)  st_compliance <= 1'b1;
      if (set_fail)    st_fail <= 1'b1;
      // a failed port also passes the absent step; it keeps only the fail flag
      if (set_absent && !st_fail) st_not_present <= 1'b1;
      if (set_done)    done <= 1'b1;
    end
  end

endmodule

// File: rtl/link_bringup_sup.sv
module link_bringup_sup #(
  parameter int TS_W              = 32,
  parameter int CODE_W            = 6,
  parameter int LANE_W            = 5,
  parameter int PRESENCE_CODE_MAX = 4,
  parameter int ACTIVE_CODE       = 16,
  parameter int VC_TIMEOUT_US     = 1000000,
  parameter int WA_TIMEOUT_US     = 3000000,
  parameter int WA_RETRY_MAX      = 5,
  parameter int WA_MIN_LANES      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   ts_us,
  input  logic [TS_W-1:0]   dur_rst_assert,
  input  logic [TS_W-1:0]   dur_rst_to_train,
  input  logic [TS_W-1:0]   dur_rx_detect,
  input  logic [TS_W-1:0]   dur_l0_wait,
  input  logic [CODE_W-1:0] link_code,
  input  logic [1:0]        verdict,
  input  logic [LANE_W-1:0] neg_width,
  input  logic [LANE_W-1:0] phy_lanes,
  input  logic              vc_pending,
  input  logic              cfg_compliance,
  input  logic              cfg_hotplug,
  input  logic              cfg_wa_en,
  input  logic              cfg_gen1_cap,
  input  logic [1:0]        wa_status,
  output logic              slot_rst,
  output logic              link_dis,
  output logic              hold_train,
  output logic              retrain,
  output logic              width_req,
  output logic [LANE_W-1:0] width_val,
  output logic              gen1_req,
  output logic              bw_mgmt_set,
  output logic              st_success,
  output logic              st_compliance,
  output logic              st_fail,
  output logic              st_not_present,
  output logic              done
);
  import lbs_pkg::*;

  localparam logic [TS_W-1:0]   VC_LIMIT  = TS_W'(VC_TIMEOUT_US);
  localparam logic [TS_W-1:0]   WA_LIMIT  = TS_W'(WA_TIMEOUT_US);
  localparam logic [CODE_W-1:0] CODE_PRES = CODE_W'(PRESENCE_CODE_MAX);
  localparam logic [CODE_W-1:0] CODE_L0   = CODE_W'(ACTIVE_CODE);
  localparam logic [LANE_W-1:0] LANES_WA  = LANE_W'(WA_MIN_LANES);

  lbs_state_e state_q, state_d;

  logic [TS_W-1:0] elapsed;
  logic            timer_restart;
  logic            retry_exhausted;
  logic            gen1_forced_q;

  // named internal events
  logic ev_rst_on, ev_rst_off, ev_release;
  logic ev_width, ev_gen1, ev_retrain, ev_retry;
  logic ev_success, ev_comply, ev_fail, ev_absent, ev_done;

  function automatic logic reached(input logic [TS_W-1:0] el,
                                   input logic [TS_W-1:0] lim);
    return el >= lim;
  endfunction

  function automatic logic partial_width(input logic [LANE_W-1:0] neg,
                                         input logic [LANE_W-1:0] phy);
    return (neg != '0) && (neg < phy);
  endfunction

  function automatic lbs_state_e verdict_step(input logic [1:0] v);
    case (v)
      VERDICT_COMPLY: return ST_COMPLY;
      VERDICT_BROKEN: return ST_BROKEN;
      VERDICT_SPEED:  return ST_SPEED;
      default:        return ST_FAIL;
    endcase
  endfunction

  logic gen1_now;
  logic wa_needed;
  assign gen1_now  = cfg_gen1_cap | gen1_forced_q;
  assign wa_needed = cfg_wa_en && (phy_lanes >= LANES_WA);

  lbs_timer #(.TS_W(TS_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ts      (ts_us),
    .restart (timer_restart),
    .elapsed (elapsed)
  );

  lbs_retry #(.LIMIT(WA_RETRY_MAX)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .bump      (ev_retry),
    .exhausted (retry_exhausted)
  );

  lbs_outcome u_outcome (
    .clk            (clk),
    .rst_n          (rst_n),
    .set_success    (ev_success),
    .set_comply     (ev_comply),
    .set_fail       (ev_fail),
    .set_absent     (ev_absent),
    .set_done       (ev_done),
    .st_success     (st_success),
    .st_compliance  (st_compliance),
    .st_fail        (st_fail),
    .st_not_present (st_not_present),
    .done           (done)
  );

  always_comb begin
    state_d       = state_q;
    timer_restart = 1'b0;
    ev_rst_on     = 1'b0;
    ev_rst_off    = 1'b0;
    ev_release    = 1'b0;
    ev_width      = 1'b0;
    ev_gen1       = 1'b0;
    ev_retrain    = 1'b0;
    ev_retry      = 1'b0;
    ev_success    = 1'b0;
    ev_comply     = 1'b0;
    ev_fail       = 1'b0;
    ev_absent     = 1'b0;
    ev_done       = 1'b0;
    unique case (state_q)
      ST_RST_ENTER: begin
        ev_rst_on     = 1'b1;
        timer_restart = 1'b1;
        state_d       = ST_RST_HOLD;
      end
      ST_RST_HOLD: begin
        if (reached(elapsed, dur_rst_assert)) state_d = ST_RST_EXIT;
      end
      ST_RST_EXIT: begin
        ev_rst_off    = 1'b1;
        timer_restart = 1'b1;
        state_d       = ST_TRAIN_WAIT;
      end
      ST_TRAIN_WAIT: begin
        if (reached(elapsed, dur_rst_to_train)) state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        ev_release    = 1'b1;
        timer_restart = 1'b1;
        state_d       = cfg_compliance ? ST_COMPLY : ST_PRESENCE;
      end
      ST_PRESENCE: begin
        if (link_code > CODE_PRES) begin
          timer_restart = 1'b1;
          state_d       = ST_DETECT;
        end else if (reached(elapsed, dur_rx_detect)) begin
          state_d = ST_ABSENT;
        end
      end
      ST_DETECT: begin
        if (link_code == CODE_L0) begin
          state_d = ST_L0;
        end else if (reached(elapsed, dur_l0_wait)) begin
          state_d = verdict_step(verdict);
        end
      end
      ST_BROKEN: begin
        if (partial_width(neg_width, phy_lanes)) begin
          ev_width = 1'b1;
          state_d  = ST_RST_ENTER;
        end else begin
          state_d = ST_SPEED;
        end
      end
      ST_SPEED: begin
        if (!gen1_now) begin
          ev_gen1 = 1'b1;
          state_d = ST_RST_ENTER;
        end else begin
          state_d = ST_FAIL;
        end
      end
      ST_L0: begin
        timer_restart = 1'b1;
        state_d       = ST_VC_WAIT;
      end
      ST_VC_WAIT: begin
        if (!vc_pending) begin
          if (wa_needed) begin
            timer_restart = 1'b1;
            state_d       = ST_WA;
          end else begin
            state_d = ST_SUCCESS;
          end
        end else if (reached(elapsed, VC_LIMIT)) begin
          state_d = ST_RETRAIN;
        end
      end
      ST_RETRAIN: begin
        ev_retrain    = 1'b1;
        timer_restart = 1'b1;
        state_d       = ST_DETECT;
      end
      ST_WA: begin
        case (wa_status)
          WA_OK: state_d = ST_SUCCESS;
          WA_RESET_DEV: begin
            if (!retry_exhausted) begin
              ev_retry = 1'b1;
              state_d  = ST_RST_ENTER;
            end else begin
              state_d = ST_FAIL;
            end
          end
          default: begin
            if (reached(elapsed, WA_LIMIT)) state_d = ST_FAIL;
          end
        endcase
      end
      ST_FAIL: begin
        ev_fail = 1'b1;
        state_d = ST_ABSENT;
      end
      ST_ABSENT: begin
        ev_absent = 1'b1;
        state_d   = ST_DONE;
      end
      ST_SUCCESS: begin
        ev_success = 1'b1;
        state_d    = ST_DONE;
      end
      ST_COMPLY: begin
        ev_comply = 1'b1;
        state_d   = ST_DONE;
      end
      ST_DONE: begin
        ev_done = 1'b1;
      end
      default: state_d = ST_RST_ENTER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RST_ENTER;
    end else begin
      state_q <= state_d;
    end
  end

  // level controls toward the slot and the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_rst   <= 1'b0;
      link_dis   <= 1'b0;
      hold_train <= 1'b1;
    end else begin
      if (ev_rst_on) begin
        slot_rst <= 1'b1;
        link_dis <= 1'b1;
      end else if (ev_rst_off) begin
        slot_rst <= 1'b0;
        link_dis <= 1'b0;
      end
      if (ev_release) begin
        hold_train <= 1'b0;
      end else if (ev_absent && !cfg_hotplug) begin
        hold_train <= 1'b1;
      end
    end
  end

  // one-cycle strobes and recovery bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retrain       <= 1'b0;
      width_req     <= 1'b0;
      width_val     <= '0;
      gen1_req      <= 1'b0;
      bw_mgmt_set   <= 1'b0;
      gen1_forced_q <= 1'b0;
    end else begin
      retrain     <= ev_retrain;
      width_req   <= ev_width;
      gen1_req    <= ev_gen1;
      bw_mgmt_set <= ev_success;
      if (ev_width) width_val <= neg_width;
      if (ev_gen1)  gen1_forced_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int LANE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_rst,
  input logic              link_dis,
  input logic              hold_train,
  input logic              retrain,
  input logic              width_req,
  input logic [LANE_W-1:0] width_val,
  input logic              gen1_req,
  input logic              bw_mgmt_set,
  input logic              st_success,
  input logic              st_compliance,
  input logic              st_fail,
  input logic              st_not_present,
  input logic              done
);

  assert_rst_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rst |-> link_dis);

  assert_release_after_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_train) |-> (!slot_rst && !link_dis));

  assert_width_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    width_req |-> (width_val != '0));

  assert_gen1_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gen1_req |=> !gen1_req);

  assert_retrain_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> !retrain);

  assert_bw_with_success_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bw_mgmt_set |-> $rose(st_success));

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_success, st_compliance, st_fail, st_not_present}));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_done_has_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({st_success, st_compliance, st_fail, st_not_present} != 4'b0));

endmodule

bind link_bringup_sup lbs_checker #(.LANE_W(LANE_W)) u_lbs_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .slot_rst       (slot_rst),
  .link_dis       (link_dis),
  .hold_train     (hold_train),
  .retrain        (retrain),
  .width_req      (width_req),
  .width_val      (width_val),
  .gen1_req       (gen1_req),
  .bw_mgmt_set    (bw_mgmt_set),
  .st_success     (st_success),
  .st_compliance  (st_compliance),
  .st_fail        (st_fail),
  .st_not_present (st_not_present),
  .done           (done)
);

// File: tb/link_bringup_sup_test.sv
module link_bringup_sup_test;

  localparam int OUT_SUCC = 8, OUT_COMP = 4, OUT_FAIL = 2, OUT_NP = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cyc = '0;
  logic [31:0] offset = '0;
  logic [31:0] ts_us;
  logic [31:0] d_rst = 32'd3, d_train = 32'd3, d_rx = 32'd5, d_l0 = 32'd5;
  logic [5:0]  link_code = '0;
  logic [1:0]  verdict = '0;
  logic [4:0]  neg_width = '0;
  logic [4:0]  lanes_init = 5'd4;
  logic [4:0]  phy_lanes;
  logic        vc_pending = 1'b0;
  logic        cfg_compliance = 1'b0, cfg_hotplug = 1'b0, cfg_wa_en = 1'b0, cfg_gen1_cap = 1'b0;
  logic [1:0]  wa_status = 2'd1;
  logic        slot_rst, link_dis, hold_train, retrain, width_req, gen1_req, bw_mgmt_set;
  logic [4:0]  width_val;
  logic        st_success, st_compliance, st_fail, st_not_present, done;

  int n_checks = 0, n_errors = 0;
  int n_width = 0, n_gen1 = 0, n_retrain = 0, n_slot = 0, n_bw = 0;
  logic slot_prev = 1'b0;

  always #4 clk = ~clk;
  assign ts_us = cyc + offset;
  always @(posedge clk) cyc <= cyc + 1;

  // the port reacts to a width request by narrowing its lane count
  always @(posedge clk) begin
    if (!rst_n) phy_lanes <= lanes_init;
    else if (width_req) phy_lanes <= width_val;
  end

  always @(posedge clk) begin
    if (width_req) n_width <= n_width + 1;
    if (gen1_req) n_gen1 <= n_gen1 + 1;
    if (retrain) n_retrain <= n_retrain + 1;
    if (bw_mgmt_set) n_bw <= n_bw + 1;
    if (slot_rst && !slot_prev) n_slot <= n_slot + 1;
    slot_prev <= slot_rst;
  end

  link_bringup_sup uut (
    .clk(clk), .rst_n(rst_n), .ts_us(ts_us),
    .dur_rst_assert(d_rst), .dur_rst_to_train(d_train),
    .dur_rx_detect(d_rx), .dur_l0_wait(d_l0),
    .link_code(link_code), .verdict(verdict), .neg_width(neg_width),
    .phy_lanes(phy_lanes), .vc_pending(vc_pending),
    .cfg_compliance(cfg_compliance), .cfg_hotplug(cfg_hotplug),
    .cfg_wa_en(cfg_wa_en), .cfg_gen1_cap(cfg_gen1_cap), .wa_status(wa_status),
    .slot_rst(slot_rst), .link_dis(link_dis), .hold_train(hold_train),
    .retrain(retrain), .width_req(width_req), .width_val(width_val),
    .gen1_req(gen1_req), .bw_mgmt_set(bw_mgmt_set),
    .st_success(st_success), .st_compliance(st_compliance),
    .st_fail(st_fail), .st_not_present(st_not_present), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int outcome_now();
    return {28'd0, st_success, st_compliance, st_fail, st_not_present};
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input int max_cyc);
    for (int k = 0; k < max_cyc && !done; k++) @(negedge clk);
  endtask

  // reference outcome from the requirements
  task automatic predict(input bit comp, input int cls, input int code_v,
                         input int verd, input int lanes, input int w,
                         input bit gen1, input bit hp, input bit wa_en,
                         input int wa_st, output int outc, output int nw,
                         output int ng, output int ns, output bit hold);
    nw = 0; ng = 0; ns = 1; hold = 1'b0;
    if (comp) begin
      outc = OUT_COMP;                                 // R3
    end else if (code_v <= 4) begin
      outc = OUT_NP; hold = !hp;                       // R4
    end else if (code_v == 16) begin
      if (wa_en && lanes >= 8 && wa_st == 2) begin     // R10
        outc = OUT_FAIL; ns = 6; hold = !hp;
      end else begin
        outc = OUT_SUCC;                               // R9
      end
    end else begin
      case (verd)                                      // R5
        0: begin outc = OUT_FAIL; hold = !hp; end
        1: outc = OUT_COMP;
        default: begin
          if (verd == 2 && w != 0 && w < lanes) nw = 1; // R6
          ng = gen1 ? 0 : 1;                           // R7
          ns = 1 + nw + ng;
          outc = OUT_FAIL; hold = !hp;
        end
      endcase
    end
    if (cls < 0) outc = 0;
  endtask

  int w0, g0, s0, r0, b0;

  task automatic snap();
    w0 = n_width; g0 = n_gen1; s0 = n_slot; r0 = n_retrain; b0 = n_bw;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    int outc, nw, ng, ns, cnt;
    bit hold;
    void'($urandom(32'd24681));

    // R12 reset values
    repeat (2) @(negedge clk);
    check(!slot_rst && !link_dis && hold_train, "R12", "slot/dis/hold in reset",
          {slot_rst, link_dis, hold_train}, 3'b001);
    check(!done && outcome_now() == 0 && !retrain && !width_req && !gen1_req && !bw_mgmt_set,
          "R12", "flags and strobes in reset", outcome_now(), 0);

    // R1 / R2 reset window, measured across a timestamp wrap
    d_rst = 32'd40; d_train = 32'd6; link_code = 6'd16; lanes_init = 5'd4;
    offset = 32'hFFFF_FFFF - cyc - 32'd20;
    do_reset();
    @(negedge clk);
    check(slot_rst && link_dis, "R1", "reset asserted", {slot_rst, link_dis}, 3);
    cnt = 0;
    while (slot_rst && cnt < 200) begin cnt++; @(negedge clk); end
    check(cnt == 41, "R1", "slot reset cycles across wrap", cnt, 41);
    check(!link_dis && hold_train, "R2", "hold kept after reset release",
          {link_dis, hold_train}, 1);
    wait_done(500);
    check(st_success && !hold_train, "R2", "training released then success",
          outcome_now(), OUT_SUCC);
    offset = '0;

    // random scenarios
    for (int i = 0; i < 28; i++) begin
      int cls, code_v, lanes, w, verd, wa_st;
      bit comp, hp, wa_en, gen1;
      cls = $urandom_range(0, 9);
      comp = (cls == 0);
      code_v = (cls == 1) ? $urandom_range(0, 4) :
               (cls <= 4) ? 16 : $urandom_range(5, 15);
      lanes = 1 << $urandom_range(0, 4);
      w = $urandom_range(0, lanes);
      verd = $urandom_range(0, 3);
      hp = $urandom_range(0, 1);
      wa_en = $urandom_range(0, 1);
      gen1 = $urandom_range(0, 1);
      wa_st = $urandom_range(1, 2);
      @(negedge clk);
      d_rst = $urandom_range(1, 12); d_train = $urandom_range(1, 12);
      d_rx = $urandom_range(1, 12); d_l0 = $urandom_range(1, 12);
      cfg_compliance = comp; cfg_hotplug = hp; cfg_wa_en = wa_en; cfg_gen1_cap = gen1;
      link_code = 6'(code_v); verdict = 2'(verd); neg_width = 5'(w);
      lanes_init = 5'(lanes); wa_status = 2'(wa_st); vc_pending = 1'b0;
      predict(comp, cls, code_v, verd, lanes, w, gen1, hp, wa_en, wa_st,
              outc, nw, ng, ns, hold);
      do_reset();
      snap();
      wait_done(3000);
      repeat (2) @(negedge clk);
      check(done && outcome_now() == outc, "R11", $sformatf("outcome scenario %0d", i),
            outcome_now(), outc);
      check(n_width - w0 == nw, "R6", "width requests", n_width - w0, nw);
      check(n_gen1 - g0 == ng, "R7", "speed requests", n_gen1 - g0, ng);
      check(n_slot - s0 == ns, "R10", "slot resets", n_slot - s0, ns);
      check(hold_train == hold, "R4", "final hold", hold_train, hold);
      if (outc == OUT_SUCC)
        check(n_bw - b0 == 1, "R9", "bandwidth status strobe", n_bw - b0, 1);
      if (nw == 1)
        check(phy_lanes == 5'(w), "R6", "width value", phy_lanes, w);
    end

    // R8 virtual-channel timeout boundary
    @(negedge clk);
    d_rst = 2; d_train = 2; d_rx = 5; d_l0 = 5;
    cfg_compliance = 0; cfg_hotplug = 0; cfg_wa_en = 0; cfg_gen1_cap = 0;
    link_code = 6'd16; lanes_init = 5'd4; vc_pending = 1'b1;
    do_reset();
    snap();
    repeat (300) @(negedge clk);
    offset = offset + 32'd999000;
    repeat (10) @(negedge clk);
    check(n_retrain == r0 && !done, "R8", "no retrain below limit", n_retrain - r0, 0);
    offset = offset + 32'd1000;
    repeat (10) @(negedge clk);
    check(n_retrain - r0 == 1, "R8", "retrain at limit", n_retrain - r0, 1);
    vc_pending = 1'b0;
    wait_done(500);
    check(st_success, "R9", "success after negotiation", outcome_now(), OUT_SUCC);

    // R10 workaround not-ready timeout, R9 workaround gating
    @(negedge clk);
    cfg_wa_en = 1; lanes_init = 5'd8; wa_status = 2'd0; cfg_hotplug = 1;
    do_reset();
    repeat (300) @(negedge clk);
    offset = offset + 32'd2999000;
    repeat (10) @(negedge clk);
    check(!done, "R10", "not ready below limit", done, 0);
    offset = offset + 32'd1000;
    repeat (10) @(negedge clk);
    check(done && st_fail && !st_not_present, "R10", "not ready timeout fails",
          outcome_now(), OUT_FAIL);
    check(!hold_train, "R4", "hotplug keeps hold low", hold_train, 0);

    // R9 workaround skipped below 8 lanes
    @(negedge clk);
    lanes_init = 5'd4; wa_status = 2'd0;
    do_reset();
    wait_done(500);
    check(st_success, "R9", "narrow port skips workaround", outcome_now(), OUT_SUCC);

    // R11 done stays until reset
    repeat (20) @(negedge clk);
    check(done, "R11", "done sticky", done, 1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule